// File: doc/BRIEF.md
# Virtual Interrupt Masking and Dispatch Unit

This unit sits between the interrupt controller and the exception entry logic of a processor core. It samples four level-sensitive request lines, two physical (IRQ and FIQ) and two virtual (virtual IRQ and virtual FIQ). It then judges each pending request against the current processor state: exception level, security state, the I and F mask bits, the hypervisor routing bits for IRQ and FIQ, the microcontroller profile select and the program counter. In one cycle it chooses at most one request to take.

A take is announced by a single-cycle strobe. The strobe comes with an exception code, the exception level the exception is delivered to, and the offset of its entry within the vector table. After a take the unit stays quiet until the exception logic acknowledges. A level that is still high therefore cannot start a second entry before the first has been handled. A configuration input turns virtual-interrupt support off. When it is off, the virtual lines are ignored and an error flag reports any virtual line that is asserted.

Top module: `irq_take_unit`

## Requirements
- R1: Request line index 0 is physical IRQ, 1 is physical FIQ, 2 is virtual IRQ and 3 is virtual FIQ. Each line's pending flag follows its level one cycle late, and a request that returns low before being taken is never taken.
- R2: A physical FIQ is taken when the F mask is clear. It gives code 6, target level max(current level, 1) and offset 0x100.
- R3: A physical IRQ is taken when the IRQ unmask condition holds. It gives code 5, target level max(current level, 1) and offset 0x80.
- R4: The IRQ unmask condition is: the I mask is clear and, when the microcontroller profile is selected, the PC is below 0xFFFFFFF0. Without that profile the PC has no effect.
- R5: A virtual IRQ is taken only when the core is non-secure, the IRQ routing bit is set and the IRQ unmask condition holds. It gives code 14, target level 1 and offset 0x80.
- R6: A virtual FIQ is taken only when the core is non-secure, the FIQ routing bit is set and the F mask is clear. It gives code 15, target level 1 and offset 0x100.
- R7: No request is taken whose target level is below the current level. This means virtual requests are never taken at levels 2 and 3.
- R8: Among eligible requests the winner is chosen in this order: physical FIQ, physical IRQ, virtual IRQ, virtual FIQ.
- R9: The take strobe lasts exactly one cycle, two clock edges after the request rises. No further take occurs until the acknowledge input has been sampled high. The next take can come one edge after that.
- R10: When virtual support is disabled, virtual requests are never taken, and the error flag is high (registered, one edge after the pending flag) while either virtual line is pending.
- R11: After reset the strobe, code, level, offset and error flag are all zero and no line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_lines | input | 4 | Request levels: [0] IRQ, [1] FIQ, [2] virtual IRQ, [3] virtual FIQ |
| virt_en | input | 1 | Virtual interrupt support enabled |
| cur_el | input | 2 | Current exception level |
| is_secure | input | 1 | Core is in secure state |
| mask_i | input | 1 | IRQ mask bit |
| mask_f | input | 1 | FIQ mask bit |
| hyp_irq_route | input | 1 | Hypervisor routing bit for IRQs (enables virtual IRQ) |
| hyp_fiq_route | input | 1 | Hypervisor routing bit for FIQs (enables virtual FIQ) |
| mcu_profile | input | 1 | Microcontroller profile selected |
| pc | input | 32 | Current program counter |
| take_ack | input | 1 | Exception entry has consumed the last take |
| take_pulse | output | 1 | One-cycle strobe: an interrupt is taken |
| take_code | output | 4 | Exception code of the taken interrupt |
| take_el | output | 2 | Target exception level |
| take_vec | output | 12 | Vector offset |
| virt_err | output | 1 | Virtual line asserted while virtual support is disabled |

## Verification
The bench builds the unit with its default parameters: a 32-bit PC and a profile limit of 0xFFFFFFF0. With these values the PC boundary can be probed at exactly the limit and one below it. The table walks every gating input one at a time for each source, and it also covers multi-line collisions for the priority order. Directed tests cover the hold-off until acknowledge and a request that is dropped.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

  localparam int NUM_SRC = 4;
  localparam int EL_W    = 2;
  localparam int CODE_W  = 4;
  localparam int VEC_W   = 12;

  typedef enum logic [1:0] {
    SRC_IRQ  = 2'd0,
    SRC_FIQ  = 2'd1,
    SRC_VIRQ = 2'd2,
    SRC_VFIQ = 2'd3
  } src_e;

  localparam logic [CODE_W-1:0] CODE_IRQ  = 4'd5;
  localparam logic [CODE_W-1:0] CODE_FIQ  = 4'd6;
  localparam logic [CODE_W-1:0] CODE_VIRQ = 4'd14;
  localparam logic [CODE_W-1:0] CODE_VFIQ = 4'd15;

  localparam logic [VEC_W-1:0] VEC_IRQ_CLASS = 12'h080;
  localparam logic [VEC_W-1:0] VEC_FIQ_CLASS = 12'h100;

  function automatic logic [CODE_W-1:0] src_code(input src_e s);
    case (s)
      SRC_IRQ:  return CODE_IRQ;
      SRC_FIQ:  return CODE_FIQ;
      SRC_VIRQ: return CODE_VIRQ;
      default:  return CODE_VFIQ;
    endcase
  endfunction

  function automatic logic [EL_W-1:0] src_target_el(input src_e s, input logic [EL_W-1:0] el);
    if (s == SRC_VIRQ || s == SRC_VFIQ) return 2'd1;
    return (el == 2'd0) ? 2'd1 : el;
  endfunction

  function automatic logic [VEC_W-1:0] src_vec(input src_e s);
    if (s == SRC_FIQ || s == SRC_VFIQ) return VEC_FIQ_CLASS;
    return VEC_IRQ_CLASS;
  endfunction

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= lines[g];
    end
  end
endmodule

// File: rtl/irq_eligibility.sv
module irq_eligibility
  import irq_take_pkg::*;
#(
  parameter int              PC_W         = 32,
  parameter logic [PC_W-1:0] MCU_PC_LIMIT = 32'hFFFF_FFF0
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic               virt_en,
  input  logic [EL_W-1:0]    cur_el,
  input  logic               is_secure,
  input  logic               mask_i,
  input  logic               mask_f,
  input  logic               hyp_irq_route,
  input  logic               hyp_fiq_route,
  input  logic               mcu_profile,
  input  logic [PC_W-1:0]    pc,
  output logic [NUM_SRC-1:0] elig,
  output logic               irq_open
);
  function automatic logic irq_unmasked(input logic mi, input logic mcu, input logic [PC_W-1:0] p);
    return !mi && (!mcu || (p < MCU_PC_LIMIT));
  endfunction

  assign irq_open = irq_unmasked(mask_i, mcu_profile, pc);

  logic [NUM_SRC-1:0] gate_ok;
  logic [NUM_SRC-1:0] level_ok;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam src_e S = src_e'(g);
    always_comb begin
      case (S)
        SRC_IRQ:  gate_ok[g] = irq_open;
        SRC_FIQ:  gate_ok[g] = !mask_f;
        SRC_VIRQ: gate_ok[g] = virt_en && !is_secure && hyp_irq_route && irq_open;
        default:  gate_ok[g] = virt_en && !is_secure && hyp_fiq_route && !mask_f;
      endcase
    end
    assign level_ok[g] = (src_target_el(S, cur_el) >= cur_el);
    assign elig[g]     = pend[g] && gate_ok[g] && level_ok[g];
  end

  // R10: virtual sources never eligible with support disabled
  a_r10_virt_gated: assert final (!((virt_en == 1'b0) && (elig[2] || elig[3])));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_take_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] elig,
  output logic [NUM_SRC-1:0] grant,
  output src_e               win,
  output logic               any
);
  localparam src_e ORDER [NUM_SRC] = '{SRC_FIQ, SRC_IRQ, SRC_VIRQ, SRC_VFIQ};

  always_comb begin
    win = SRC_IRQ;
    any = 1'b0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (elig[ORDER[k]]) begin
        win = ORDER[k];
        any = 1'b1;
      end
    end
    grant = '0;
    if (any) grant[win] = 1'b1;
  end

  // R8: at most one winner, and only from the eligible set
  a_r8_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~elig) == '0));
  // R8: an eligible FIQ always wins
  a_r8_fiq_first: assert property (@(posedge clk) disable iff (!rst_n)
    elig[1] |-> grant[1]);
endmodule

// File: rtl/irq_take_unit.sv
module irq_take_unit
  import irq_take_pkg::*;
#(
  parameter int              PC_W         = 32,
  parameter logic [PC_W-1:0] MCU_PC_LIMIT = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        req_lines,
  input  logic              virt_en,
  input  logic [1:0]        cur_el,
  input  logic              is_secure,
  input  logic              mask_i,
  input  logic              mask_f,
  input  logic              hyp_irq_route,
  input  logic              hyp_fiq_route,
  input  logic              mcu_profile,
  input  logic [PC_W-1:0]   pc,
  input  logic              take_ack,
  output logic              take_pulse,
  output logic [3:0]        take_code,
  output logic [1:0]        take_el,
  output logic [11:0]       take_vec,
  output logic              virt_err
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  logic               irq_open;
  logic               any_elig;
  src_e               win;
  logic               busy_q;
  logic               take_fire;
  logic               virt_pending;

  irq_req_capture #(.N(NUM_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .lines(req_lines), .pend(pend)
  );

  irq_eligibility #(.PC_W(PC_W), .MCU_PC_LIMIT(MCU_PC_LIMIT)) u_elig (
    .pend(pend), .virt_en(virt_en), .cur_el(cur_el), .is_secure(is_secure),
    .mask_i(mask_i), .mask_f(mask_f), .hyp_irq_route(hyp_irq_route),
    .hyp_fiq_route(hyp_fiq_route), .mcu_profile(mcu_profile), .pc(pc),
    .elig(elig), .irq_open(irq_open)
  );

  irq_prio_pick u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .grant(grant), .win(win), .any(any_elig)
  );

  assign take_fire    = any_elig && !busy_q;
  assign virt_pending = pend[SRC_VIRQ] || pend[SRC_VFIQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_pulse <= 1'b0;
      take_code  <= '0;
      take_el    <= '0;
      take_vec   <= '0;
      busy_q     <= 1'b0;
      virt_err   <= 1'b0;
    end else begin
      take_pulse <= take_fire;
      virt_err   <= !virt_en && virt_pending;
      if (take_fire) begin
        take_code <= src_code(win);
        take_el   <= src_target_el(win, cur_el);
        take_vec  <= src_vec(win);
        busy_q    <= 1'b1;
      end else if (take_ack) begin
        busy_q    <= 1'b0;
      end
    end
  end

  // R9: strobe never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |=> !take_pulse);
  // R7: delivered level is never below the level at decision time
  a_r7_no_lower_el: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> (take_el >= $past(cur_el)));
  // R5: virtual IRQ goes to level 1, IRQ offset, only when non-secure and routed
  a_r5_virq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_code == CODE_VIRQ) |->
      (take_el == 2'd1 && take_vec == VEC_IRQ_CLASS && !$past(is_secure) && $past(hyp_irq_route)));
  // R6: virtual FIQ goes to level 1, FIQ offset, only when non-secure and routed
  a_r6_vfiq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_code == CODE_VFIQ) |->
      (take_el == 2'd1 && take_vec == VEC_FIQ_CLASS && !$past(is_secure) && $past(hyp_fiq_route)));
  // R10: nothing virtual is taken while support is off
  a_r10_no_virt_take: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && !$past(virt_en)) |-> (take_code != CODE_VIRQ && take_code != CODE_VFIQ));
  // R4: IRQ-class takes require the unmask window at decision time
  a_r4_irq_window: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_vec == VEC_IRQ_CLASS) |-> $past(irq_open));
endmodule

// File: tb/sim_irq_take_unit.sv
module sim_irq_take_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 30;

  typedef struct packed {
    logic [3:0]  req;
    logic        ven;
    logic [1:0]  el;
    logic        sec;
    logic        mi;
    logic        mf;
    logic        imo;
    logic        fmo;
    logic        mcu;
    logic [1:0]  psel;
    logic        take;
    logic [3:0]  code;
    logic [1:0]  tel;
    logic [11:0] vec;
    logic        err;
  } vec_t;

  // req ven el sec mi mf imo fmo mcu psel | take code tel vec err
  localparam vec_t VECS [NV] = '{
    '{4'b0010,1,2'd0,0,0,0,0,0,0,2'd0, 1,4'd6, 2'd1,12'h100,0}, // R2
    '{4'b0010,1,2'd2,0,0,0,0,0,0,2'd0, 1,4'd6, 2'd2,12'h100,0}, // R2 at level 2
    '{4'b0010,1,2'd0,0,0,1,0,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R2 masked
    '{4'b0001,1,2'd0,0,0,0,0,0,0,2'd0, 1,4'd5, 2'd1,12'h080,0}, // R3
    '{4'b0001,1,2'd3,1,0,0,0,0,0,2'd0, 1,4'd5, 2'd3,12'h080,0}, // R3 at level 3
    '{4'b0001,1,2'd0,0,1,0,0,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R3 masked
    '{4'b0001,1,2'd0,0,0,0,0,0,1,2'd1, 0,4'd0, 2'd0,12'h000,0}, // R4 pc high
    '{4'b0001,1,2'd0,0,0,0,0,0,1,2'd0, 1,4'd5, 2'd1,12'h080,0}, // R4 pc low
    '{4'b0001,1,2'd0,0,0,0,0,0,0,2'd1, 1,4'd5, 2'd1,12'h080,0}, // R4 no profile
    '{4'b0001,1,2'd0,0,0,0,0,0,1,2'd2, 0,4'd0, 2'd0,12'h000,0}, // R4 pc at limit
    '{4'b0001,1,2'd0,0,0,0,0,0,1,2'd3, 1,4'd5, 2'd1,12'h080,0}, // R4 pc limit-1
    '{4'b0100,1,2'd1,0,0,0,1,0,0,2'd0, 1,4'd14,2'd1,12'h080,0}, // R5
    '{4'b0100,1,2'd1,1,0,0,1,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R5 secure
    '{4'b0100,1,2'd1,0,0,0,0,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R5 not routed
    '{4'b0100,1,2'd1,0,1,0,1,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R5 I masked
    '{4'b0100,1,2'd0,0,0,0,1,0,1,2'd1, 0,4'd0, 2'd0,12'h000,0}, // R5 pc window
    '{4'b1000,1,2'd0,0,0,0,0,1,0,2'd0, 1,4'd15,2'd1,12'h100,0}, // R6
    '{4'b1000,1,2'd0,0,0,0,0,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R6 not routed
    '{4'b1000,1,2'd0,0,0,1,0,1,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R6 F masked
    '{4'b1000,1,2'd0,1,0,0,0,1,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R6 secure
    '{4'b0100,1,2'd2,0,0,0,1,0,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R7 VIRQ at 2
    '{4'b1000,1,2'd3,0,0,0,0,1,0,2'd0, 0,4'd0, 2'd0,12'h000,0}, // R7 VFIQ at 3
    '{4'b1111,1,2'd0,0,0,0,1,1,0,2'd0, 1,4'd6, 2'd1,12'h100,0}, // R8 FIQ wins
    '{4'b1101,1,2'd0,0,0,0,1,1,0,2'd0, 1,4'd5, 2'd1,12'h080,0}, // R8 IRQ next
    '{4'b1100,1,2'd0,0,0,0,1,1,0,2'd0, 1,4'd14,2'd1,12'h080,0}, // R8 VIRQ over VFIQ
    '{4'b1111,1,2'd0,0,0,1,1,1,0,2'd0, 1,4'd5, 2'd1,12'h080,0}, // R8 FIQ masked
    '{4'b1100,1,2'd0,0,1,0,1,1,0,2'd0, 1,4'd15,2'd1,12'h100,0}, // R8 VFIQ last
    '{4'b0100,0,2'd1,0,0,0,1,1,0,2'd0, 0,4'd0, 2'd0,12'h000,1}, // R10 VIRQ off
    '{4'b1000,0,2'd1,0,0,0,1,1,0,2'd0, 0,4'd0, 2'd0,12'h000,1}, // R10 VFIQ off
    '{4'b1101,0,2'd0,0,0,0,1,1,0,2'd0, 1,4'd5, 2'd1,12'h080,1}  // R10 IRQ still
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_lines = '0;
  logic        virt_en = 1'b1;
  logic [1:0]  cur_el = '0;
  logic        is_secure = 1'b0, mask_i = 1'b0, mask_f = 1'b0;
  logic        hyp_irq_route = 1'b0, hyp_fiq_route = 1'b0, mcu_profile = 1'b0;
  logic [31:0] pc = 32'h0000_1000;
  logic        take_ack = 1'b0;
  logic        take_pulse;
  logic [3:0]  take_code;
  logic [1:0]  take_el;
  logic [11:0] take_vec;
  logic        virt_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_take_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .virt_en(virt_en),
    .cur_el(cur_el), .is_secure(is_secure), .mask_i(mask_i), .mask_f(mask_f),
    .hyp_irq_route(hyp_irq_route), .hyp_fiq_route(hyp_fiq_route),
    .mcu_profile(mcu_profile), .pc(pc), .take_ack(take_ack),
    .take_pulse(take_pulse), .take_code(take_code), .take_el(take_el),
    .take_vec(take_vec), .virt_err(virt_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pc_of(input logic [1:0] s);
    case (s)
      2'd0: return 32'h0000_1000;
      2'd1: return 32'hFFFF_FFF4;
      2'd2: return 32'hFFFF_FFF0;
      default: return 32'hFFFF_FFEF;
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    string tag;
    @(negedge clk);
    req_lines = v.req; virt_en = v.ven; cur_el = v.el; is_secure = v.sec;
    mask_i = v.mi; mask_f = v.mf; hyp_irq_route = v.imo; hyp_fiq_route = v.fmo;
    mcu_profile = v.mcu; pc = pc_of(v.psel);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    tag = $sformatf("vector %0d (R1..) strobe", idx);
    check(tag, 32'(take_pulse), 32'(v.take));
    if (v.take) begin
      check($sformatf("vector %0d code", idx), 32'(take_code), 32'(v.code));
      check($sformatf("vector %0d level", idx), 32'(take_el), 32'(v.tel));
      check($sformatf("vector %0d offset", idx), 32'(take_vec), 32'(v.vec));
    end
    check($sformatf("vector %0d R10 error flag", idx), 32'(virt_err), 32'(v.err));
    req_lines = '0; take_ack = 1'b1;
    @(negedge clk); take_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 strobe in reset", 32'(take_pulse), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 strobe", 32'(take_pulse), 32'd0);
    check("R11 code", 32'(take_code), 32'd0);
    check("R11 level", 32'(take_el), 32'd0);
    check("R11 offset", 32'(take_vec), 32'd0);
    check("R11 error", 32'(virt_err), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9: hold-off until acknowledge, with IRQ held high
    @(negedge clk);
    virt_en = 1'b1; cur_el = 2'd0; is_secure = 1'b0; mask_i = 1'b0; mask_f = 1'b0;
    hyp_irq_route = 1'b0; hyp_fiq_route = 1'b0; mcu_profile = 1'b0; pc = 32'h1000;
    req_lines = 4'b0001;
    @(negedge clk);
    check("R9 no strobe one edge after rise", 32'(take_pulse), 32'd0);
    @(negedge clk);
    check("R9 strobe two edges after rise", 32'(take_pulse), 32'd1);
    check("R9 code", 32'(take_code), 32'd5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 quiet before ack", 32'(take_pulse), 32'd0);
    end
    take_ack = 1'b1;
    @(negedge clk);
    take_ack = 1'b0;
    check("R9 no strobe on ack edge", 32'(take_pulse), 32'd0);
    @(negedge clk);
    check("R9 retake after ack", 32'(take_pulse), 32'd1);
    // R1: line dropped, acknowledged, no further take
    req_lines = '0; take_ack = 1'b1;
    @(negedge clk);
    take_ack = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 dropped line not taken", 32'(take_pulse), 32'd0);
    end
    // R1: physical FIQ held while masked, dropped before unmask: never taken
    mask_f = 1'b1; req_lines = 4'b0010;
    repeat (3) @(negedge clk);
    req_lines = '0;
    @(negedge clk);
    mask_f = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R1 released request not taken", 32'(take_pulse), 32'd0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule